// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up-Counter with Coherent Low-Byte Staging

This block is a 16-bit up-counting timer, or event counter, that an 8-bit host bus reaches one byte at a time. The host never touches the counter's low byte directly. Low-byte writes go into a single staging register. A high-byte write then moves the staged byte and the new high byte into the counter on the same clock edge.

Reads work the other way round. Reading the high byte also copies the live low byte into the staging register, so a later low-byte read returns a value that matches the high byte already read. To preload, software writes low then high. To read, it reads high then low.

Counting happens on each cycle where both the run enable and the count tick are high. When the counter wraps past its top value, it reloads the last 16-bit value written through the high byte and raises a one-cycle overflow pulse. A divider output flips on every overflow, which gives a divided-frequency square wave.

Top module: `tmr16_bytebuf`

## Requirements
- R1: A low-byte write (`wr_lo`) stores `wdata` in the staging register only; the counter value does not change because of it.
- R2: A high-byte write (`wr_hi`) loads the counter with `{wdata, staging register}` on the same edge, and that 16-bit value becomes the reload value.
- R3: While `rd_hi` is high, `rdata` shows the counter's upper byte; at the clock edge the counter's lower byte is copied into the staging register.
- R4: While `rd_lo` is high (and `rd_hi` is low), `rdata` shows the staging register rather than the live count; with no read strobe, `rdata` is 0.
- R5: The counter adds one on every edge where `run_en` and `tick` are both high, and holds its value otherwise.
- R6: An enabled tick at 0xFFFF loads the reload value instead of counting. `ovf_pulse` is high for exactly the one cycle after that edge.
- R7: `div_out` inverts in the cycle `ovf_pulse` is high and is otherwise steady.
- R8: A high-byte write in the same cycle as an enabled tick takes priority: the counter takes the written value, does not increment and does not overflow.
- R9: Synchronous reset `rst` clears the counter, the staging register, the reload value, `ovf_pulse` and `div_out`.
- R10: If `wr_lo` and `rd_hi` occur in the same cycle, the staging register keeps the written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter run enable |
| tick | input | 1 | Count event / clock enable |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| wdata | input | HALF_W (8) | Write data byte |
| rdata | output | HALF_W (8) | Read data byte (combinational) |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| div_out | output | 1 | Toggle output, inverts on each overflow |

## Verification
The bench builds the block with its default byte width of 8, so the counter spans the full 16-bit range. Preloads just below 0xFFFF reach the wrap, the reload and the divider toggle within a few ticks. A single run of 65536 back-to-back ticks from the reset value crosses the whole count range and should produce exactly one overflow. With the 8-bit width, the staging register is also a real byte, so a captured low byte can be shown to differ from the live count after further ticks.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    // What the counter register does on a given edge
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_INC  = 2'd2,
        CNT_WRAP = 2'd3
    } cnt_action_e;

    // Byte-bus strobes grouped together
    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } bus_strobe_t;

    // Bus load beats counting; wrap replaces increment at the top value
    function automatic cnt_action_e pick_action(
        input logic load_req,
        input logic step,
        input logic at_top
    );
        if (load_req)
            return CNT_LOAD;
        else if (step && at_top)
            return CNT_WRAP;
        else if (step)
            return CNT_INC;
        else
            return CNT_HOLD;
    endfunction

endpackage

// File: rtl/tmr16_lobuf.sv
module tmr16_lobuf #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              rd_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] live_lo,
    output logic [HALF_W-1:0] buf_q
);

    // A host write wins over a capture from a high-byte read
    always_ff @(posedge clk) begin
        if (rst)
            buf_q <= '0;
        else if (wr_lo)
            buf_q <= wdata;
        else if (rd_hi)
            buf_q <= live_lo;
    end

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                tick,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [HALF_W-1:0]   buf_lo,
    output logic [2*HALF_W-1:0] cnt_q,
    output logic [2*HALF_W-1:0] preload_q,
    output logic                wrap_q
);

    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    cnt_action_e      act;
    logic [CNT_W-1:0] load_val;

    assign load_val = {wdata, buf_lo};
    assign act      = pick_action(wr_hi, run_en & tick, cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            preload_q <= '0;
            wrap_q    <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            unique case (act)
                CNT_LOAD: begin
                    cnt_q     <= load_val;
                    preload_q <= load_val;
                end
                CNT_INC:  cnt_q <= cnt_q + 1'b1;
                CNT_WRAP: begin
                    cnt_q  <= preload_q;
                    wrap_q <= 1'b1;
                end
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tmr16_divout.sv
module tmr16_divout (
    input  logic clk,
    input  logic rst,
    input  logic wrap_now,
    output logic div_q
);

    // Toggles on the same edge that raises the overflow pulse
    always_ff @(posedge clk) begin
        if (rst)
            div_q <= 1'b0;
        else if (wrap_now)
            div_q <= ~div_q;
    end

endmodule

// File: rtl/tmr16_bytebuf.sv
module tmr16_bytebuf
    import tmr16_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              ovf_pulse,
    output logic              div_out
);

    localparam int CNT_W = 2 * HALF_W;

    bus_strobe_t       bus;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  preload_q;
    logic [HALF_W-1:0] lobuf_q;
    logic              wrap_q;
    logic              wrap_now;

    assign bus = '{wr_lo: wr_lo, wr_hi: wr_hi, rd_lo: rd_lo, rd_hi: rd_hi};

    // The next edge wraps when an enabled tick meets the top value without a load
    assign wrap_now = run_en & tick & ~bus.wr_hi & (&cnt_q);

    tmr16_lobuf #(.HALF_W(HALF_W)) u_lobuf (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (bus.wr_lo),
        .rd_hi   (bus.rd_hi),
        .wdata   (wdata),
        .live_lo (cnt_q[HALF_W-1:0]),
        .buf_q   (lobuf_q)
    );

    tmr16_core #(.HALF_W(HALF_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .tick      (tick),
        .wr_hi     (bus.wr_hi),
        .wdata     (wdata),
        .buf_lo    (lobuf_q),
        .cnt_q     (cnt_q),
        .preload_q (preload_q),
        .wrap_q    (wrap_q)
    );

    tmr16_divout u_div (
        .clk      (clk),
        .rst      (rst),
        .wrap_now (wrap_now),
        .div_q    (div_out)
    );

    assign ovf_pulse = wrap_q;

    always_comb begin
        if (bus.rd_hi)
            rdata = cnt_q[CNT_W-1:HALF_W];
        else if (bus.rd_lo)
            rdata = lobuf_q;
        else
            rdata = '0;
    end

endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                run_en,
    input logic                tick,
    input logic                wr_lo,
    input logic                wr_hi,
    input logic                rd_lo,
    input logic                rd_hi,
    input logic [HALF_W-1:0]   wdata,
    input logic [HALF_W-1:0]   rdata,
    input logic                ovf_pulse,
    input logic                div_out,
    input logic [2*HALF_W-1:0] cnt,
    input logic [2*HALF_W-1:0] preload,
    input logic [HALF_W-1:0]   lobuf
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_lo_write_keeps_count_R1: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(wr_lo && !wr_hi && !(run_en && tick)) |-> cnt == $past(cnt));

    assert_hi_write_loads_R2: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(wr_hi) |-> (cnt == {$past(wdata), $past(lobuf)}) && (preload == cnt));

    assert_hi_read_captures_R3: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(rd_hi && !wr_lo) |-> lobuf == $past(cnt[HALF_W-1:0]));

    assert_lo_read_buffer_R4: assert property (@(posedge clk) disable iff (rst || !seen)
        (rd_lo && !rd_hi) |-> rdata == lobuf);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(!wr_hi && !(run_en && tick)) |-> $stable(cnt));

    assert_wrap_reloads_R6: assert property (@(posedge clk) disable iff (rst || !seen)
        ovf_pulse |-> ($past(cnt) == {2*HALF_W{1'b1}}) && (cnt == $past(preload)));

    assert_div_toggles_R7: assert property (@(posedge clk) disable iff (rst || !seen)
        ovf_pulse |-> div_out != $past(div_out));

    assert_div_steady_R7: assert property (@(posedge clk) disable iff (rst || !seen)
        !ovf_pulse |-> $stable(div_out));

    assert_load_beats_tick_R8: assert property (@(posedge clk) disable iff (rst || !seen)
        $past(wr_hi && run_en && tick) |-> !ovf_pulse);

endmodule

bind tmr16_bytebuf tmr16_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .tick      (tick),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .wdata     (wdata),
    .rdata     (rdata),
    .ovf_pulse (ovf_pulse),
    .div_out   (div_out),
    .cnt       (cnt_q),
    .preload   (preload_q),
    .lobuf     (lobuf_q)
);

// File: tb/sim_tmr16_bytebuf.sv
`timescale 1ns/1ps
module sim_tmr16_bytebuf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0, tick = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ovf_pulse, div_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr16_bytebuf #(.HALF_W(8)) u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .wdata(wdata), .rdata(rdata), .ovf_pulse(ovf_pulse), .div_out(div_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; one call spans one rising edge
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; run_en = 0; tick = 0; wr_lo = 0; wr_hi = 0; rd_lo = 0; rd_hi = 0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic write16(input logic [15:0] v);
        wdata = v[7:0];  wr_lo = 1; step(); wr_lo = 0;
        wdata = v[15:8]; wr_hi = 1; step(); wr_hi = 0;
    endtask

    task automatic read16(output logic [15:0] v);
        rd_hi = 1; #0.1; v[15:8] = rdata; step(); rd_hi = 0;
        rd_lo = 1; #0.1; v[7:0]  = rdata; step(); rd_lo = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        chk("R9 ovf after reset", ovf_pulse, 0);
        chk("R9 div after reset", div_out, 0);
        chk("R4 idle rdata", rdata, 0);
        read16(v);
        chk("R9 count after reset", v, 16'h0000);
    endtask

    task automatic t_preload();
        logic [15:0] v;
        do_reset();
        wdata = 8'h34; wr_lo = 1; step(); wr_lo = 0;
        rd_lo = 1; #0.1; chk("R1 staged byte readable", rdata, 8'h34); step(); rd_lo = 0;
        rd_hi = 1; #0.1; chk("R1 high byte untouched", rdata, 8'h00); step(); rd_hi = 0;
        rd_lo = 1; #0.1; chk("R1 live low byte untouched", rdata, 8'h00); step(); rd_lo = 0;
        write16(16'h1234);
        read16(v);
        chk("R2 16-bit preload", v, 16'h1234);
    endtask

    task automatic t_count();
        logic [15:0] v;
        do_reset();
        write16(16'h1234);
        run_en = 1; tick = 1;
        for (int i = 0; i < 10; i++) step();
        tick = 0;
        step(); step();
        run_en = 0; tick = 1;
        step(); step();
        tick = 0;
        read16(v);
        chk("R5 ten ticks then hold", v, 16'h123E);
    endtask

    task automatic t_coherent();
        logic [15:0] v;
        do_reset();
        write16(16'h20FE);
        rd_hi = 1; #0.1; chk("R3 high byte read", rdata, 8'h20); step(); rd_hi = 0;
        run_en = 1; tick = 1; step(); step(); step(); tick = 0; run_en = 0;
        rd_lo = 1; #0.1; chk("R4 low read returns captured byte", rdata, 8'hFE); step(); rd_lo = 0;
        read16(v);
        chk("R5 live value moved on", v, 16'h2101);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        do_reset();
        write16(16'hFFFD);
        run_en = 1; tick = 1;
        step(); chk("R6 no ovf at FFFE", ovf_pulse, 0);
        step(); chk("R6 no ovf at FFFF", ovf_pulse, 0);
        step(); chk("R6 ovf on wrap", ovf_pulse, 1);
        chk("R7 div toggled high", div_out, 1);
        tick = 0;
        step(); chk("R6 ovf single cycle", ovf_pulse, 0);
        chk("R7 div steady", div_out, 1);
        run_en = 0;
        read16(v);
        chk("R6 reload value", v, 16'hFFFD);
        run_en = 1; tick = 1;
        step(); step(); step();
        tick = 0; run_en = 0;
        chk("R7 div toggled back", div_out, 0);
    endtask

    task automatic t_priority();
        logic [15:0] v;
        do_reset();
        write16(16'h0005);
        wdata = 8'h77; wr_lo = 1; step(); wr_lo = 0;
        run_en = 1; tick = 1; wdata = 8'h00; wr_hi = 1; step(); wr_hi = 0; tick = 0; run_en = 0;
        read16(v);
        chk("R8 write beats tick", v, 16'h0077);
        write16(16'hFFFF);
        run_en = 1; tick = 1; wdata = 8'h00; wr_hi = 1; step(); wr_hi = 0; tick = 0; run_en = 0;
        chk("R8 no ovf when write at top", ovf_pulse, 0);
        read16(v);
        chk("R8 loaded over top", v, 16'h00FF);
    endtask

    task automatic t_same_cycle();
        do_reset();
        write16(16'h5511);
        wdata = 8'hAB; wr_lo = 1; rd_hi = 1; step(); wr_lo = 0; rd_hi = 0;
        rd_lo = 1; #0.1; chk("R10 write wins over capture", rdata, 8'hAB); step(); rd_lo = 0;
    endtask

    task automatic t_full_wrap();
        logic [15:0] v;
        int ovfs = 0;
        do_reset();
        run_en = 1; tick = 1;
        for (int i = 0; i < 65536; i++) begin
            step();
            if (ovf_pulse) ovfs++;
        end
        tick = 0; run_en = 0;
        chk("R6 one ovf per full range", ovfs, 1);
        chk("R7 div after one wrap", div_out, 1);
        read16(v);
        chk("R6 reload from reset value", v, 16'h0000);
    endtask

    initial begin
        step();
        t_reset();
        t_preload();
        t_count();
        t_coherent();
        t_overflow();
        t_priority();
        t_same_cycle();
        t_full_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule